// File: doc/BRIEF.md
# In-Flight Instruction Tracker with Squash

This block keeps, for each hardware thread, a program-ordered list of the instructions that are currently in flight. Every instruction accepted into a thread's list receives that thread's next sequence number; the thread's counter starts at 1 after reset. The oldest entry leaves the list when it graduates, which also advances a per-thread committed-instruction count. A squash removes every entry of one thread whose sequence number is greater than a given squash number. A squash caused by a memory stall uses the stalling instruction's number minus one, so the stalling instruction is removed as well.

Removal is deferred. Graduation and squash only mark entries during a cycle, and all marked entries leave together at the next rising edge. An entry hit by both a graduation and a squash in the same cycle is freed once. Each thread also keeps a flag that records one active non-speculative instruction together with its sequence number. The flag clears when an entry with that number is freed. A squash also drives a registered kill mask toward the pipeline stages, covering the requesting stage and every stage in front of it.

The list depth, thread count, sequence width and stage count are parameters. The depth must be a power of two.

Top module: `inflight_tracker`

## Requirements
- R1: After reset every thread has occupancy 0, committed count 0, the non-speculative flag clear, and stageKill all zero. The first instruction accepted on each thread gets sequence number 1.
- R2: An allocation that is accepted returns the thread's current counter on allocSeq in the same cycle, and the counter then advances by one. The entry is the thread's youngest (tailSeq) after the next rising edge. headSeq and tailSeq read 0 when the list is empty.
- R3: allocAck is low while the thread's occupancy equals DEPTH. This holds even if the head graduates in the same cycle, because space is freed only at the edge.
- R4: A squash on thread T with number N removes, at the next edge, every entry of T whose sequence number is greater than N. Entries with numbers up to N stay in order.
- R5: With squashMemStall high, the squash number used is squashSeq minus one, so the entry numbered squashSeq is also removed.
- R6: One cycle after a squash, stageKill has bits 0 through squashStage set (all bits if squashStage is beyond the last stage). stageKillTid and stageKillSeq carry the thread and the squash number actually used. In a cycle after no squash, all three are zero.
- R7: A graduation on a non-empty thread removes its head at the next edge and adds one to its committed count. A graduation on an empty thread changes nothing.
- R8: When a graduation and a squash mark the same entry in one cycle, occupancy falls by the number of distinct entries marked.
- R9: A squash and an allocation on the same thread in the same cycle: the squash wins, allocAck is low and the counter does not advance. An allocation on another thread is unaffected.
- R10: nsSetReq sets the thread's non-speculative flag and records nsSeq, visible after the next edge. The flag clears at the edge at which an entry with the recorded number is freed, by graduation or by squash. Freeing other entries leaves it set. A set in the same cycle as such a free wins.
- R11: Operations on different threads in the same cycle act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request to append a new instruction |
| allocTid | input | TID_W | Thread of the append |
| allocAck | output | 1 | Append accepted this cycle |
| allocSeq | output | SEQ_W | Sequence number given to the append |
| gradReq | input | 1 | Graduate the oldest entry |
| gradTid | input | TID_W | Thread of the graduation |
| squashReq | input | 1 | Squash request |
| squashTid | input | TID_W | Thread being squashed |
| squashSeq | input | SEQ_W | Squash number (or stalling instruction's number) |
| squashMemStall | input | 1 | Squash comes from a memory stall; use squashSeq minus one |
| squashStage | input | STG_W | Stage that raised the squash |
| nsSetReq | input | 1 | Record an active non-speculative instruction |
| nsTid | input | TID_W | Thread for the record |
| nsSeq | input | SEQ_W | Sequence number recorded |
| occupancy | output | NUM_THREADS x OCC_W | Entries held per thread |
| headSeq | output | NUM_THREADS x SEQ_W | Oldest entry's number, 0 if empty |
| tailSeq | output | NUM_THREADS x SEQ_W | Youngest entry's number, 0 if empty |
| commitCnt | output | NUM_THREADS x CNT_W | Graduated instructions per thread |
| nsActive | output | NUM_THREADS | Non-speculative flag per thread |
| stageKill | output | NUM_STAGES | Registered per-stage kill mask |
| stageKillTid | output | TID_W | Thread of the registered kill |
| stageKillSeq | output | SEQ_W | Squash number of the registered kill |

## Verification
allocAck and allocSeq are combinational and are due in the same cycle as the request. Every list, counter and flag output changes at the first rising edge after the request. The kill mask and its tag are also registered once, so they show the squash one edge later. The bench drives all inputs on the falling edge and reads the acknowledge 1 ns later, before the rising edge. It reads every registered output 1 ns after the rising edge and compares it with a per-thread list model stepped in lock with that same edge. Directed sequences reach the full-list stall, squash-versus-append priority, doubly marked entries and flag clearing. A long pseudo-random sweep then mixes all operations on both threads.

// File: rtl/inflight_tracker_pkg.sv
`timescale 1ns/1ps
package inflight_tracker_pkg;

  // Per-thread strobes passed from control to datapath each cycle
  typedef struct packed {
    logic alloc;   // append at the tail
    logic grad;    // mark head for removal
    logic squash;  // mark every entry younger than the squash number
    logic nsSet;   // record a non-speculative instruction
  } trkStrobe_t;

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/trk_ctrl.sv
`timescale 1ns/1ps
module trk_ctrl
  import inflight_tracker_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,
  parameter int SEQ_W       = 16,
  parameter int NUM_STAGES  = 5,
  parameter int TID_W       = 1,
  parameter int OCC_W       = 3,
  parameter int STG_W       = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                allocReq,
  input  logic [TID_W-1:0]                    allocTid,
  input  logic                                gradReq,
  input  logic [TID_W-1:0]                    gradTid,
  input  logic                                squashReq,
  input  logic [TID_W-1:0]                    squashTid,
  input  logic [SEQ_W-1:0]                    squashSeq,
  input  logic                                squashMemStall,
  input  logic [STG_W-1:0]                    squashStage,
  input  logic                                nsSetReq,
  input  logic [TID_W-1:0]                    nsTid,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0]   occupancy,
  output trkStrobe_t [NUM_THREADS-1:0]        strobes,
  output logic [SEQ_W-1:0]                    effSeq,
  output logic                                allocAck,
  output logic [NUM_STAGES-1:0]               stageKill,
  output logic [TID_W-1:0]                    stageKillTid,
  output logic [SEQ_W-1:0]                    stageKillSeq
);

  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic allocTidOk;
  logic allocHasRoom;
  logic sameThreadSquash;
  logic [NUM_STAGES-1:0] killMask;

  // Effective squash number: a memory stall also drops the stalling entry
  always_comb begin
    effSeq = squashMemStall ? (squashSeq - SEQ_W'(1)) : squashSeq;
  end

  // Append acceptance: room in the list, and no squash on the same thread
  always_comb begin
    allocTidOk       = (int'(allocTid) < NUM_THREADS);
    allocHasRoom     = allocTidOk && (occupancy[allocTid] < FULL_OCC);
    sameThreadSquash = squashReq && (squashTid == allocTid);
    allocAck         = allocReq && allocHasRoom && !sameThreadSquash;
  end

  // Per-thread strobe decode
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      strobes[t].alloc  = allocAck && (allocTid == TID_W'(t));
      strobes[t].grad   = gradReq && (gradTid == TID_W'(t)) && (occupancy[t] != '0);
      strobes[t].squash = squashReq && (squashTid == TID_W'(t));
      strobes[t].nsSet  = nsSetReq && (nsTid == TID_W'(t));
    end
  end

  // Kill mask covers the requesting stage and every older stage below it
  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      killMask[s] = squashReq && (s <= int'(squashStage));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageKill    <= '0;
      stageKillTid <= '0;
      stageKillSeq <= '0;
    end else begin
      stageKill    <= killMask;
      stageKillTid <= squashReq ? squashTid : '0;
      stageKillSeq <= squashReq ? effSeq : '0;
    end
  end

endmodule

// File: rtl/trk_datapath.sv
`timescale 1ns/1ps
module trk_datapath
  import inflight_tracker_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,
  parameter int SEQ_W       = 16,
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 2,
  parameter int OCC_W       = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  trkStrobe_t [NUM_THREADS-1:0]        strobes,
  input  logic [SEQ_W-1:0]                    effSeq,
  input  logic [SEQ_W-1:0]                    nsSeqIn,
  output logic [NUM_THREADS-1:0][OCC_W-1:0]   occupancy,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   headSeq,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   tailSeq,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   nextSeq,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]   commitCnt,
  output logic [NUM_THREADS-1:0]              nsActive
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [SEQ_W-1:0] seqMem [DEPTH];
    logic [IDX_W-1:0] headIdx;
    logic [OCC_W-1:0] occ;
    logic [SEQ_W-1:0] seqCtr;
    logic [CNT_W-1:0] committed;
    logic             nsFlag;
    logic [SEQ_W-1:0] nsTag;

    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] mark;
    logic [DEPTH-1:0] nsHit;
    logic [OCC_W-1:0] freeCnt;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] tailIdx;
    trkStrobe_t       stb;

    assign stb = strobes[t];

    // Marking phase: graduation marks the head, a squash marks the
    // younger suffix; an entry marked by both is still one entry.
    always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [IDX_W-1:0] rel;
        rel      = IDX_W'(i) - headIdx;
        live[i]  = (OCC_W'(rel) < occ);
        mark[i]  = live[i] &&
                   ((stb.grad && (IDX_W'(i) == headIdx)) ||
                    (stb.squash && (seqMem[i] > effSeq)));
        nsHit[i] = mark[i] && (seqMem[i] == nsTag);
      end
      freeCnt = OCC_W'($countones(mark));
      wrIdx   = headIdx + IDX_W'(occ);
      tailIdx = headIdx + IDX_W'(occ - OCC_W'(1));
    end

    // Release phase: all marked entries leave together at the edge
    always_ff @(posedge clk) begin
      if (!rstN) begin
        headIdx   <= '0;
        occ       <= '0;
        seqCtr    <= SEQ_W'(1);
        committed <= '0;
        nsFlag    <= 1'b0;
        nsTag     <= '0;
        for (int i = 0; i < DEPTH; i++) seqMem[i] <= '0;
      end else begin
        if (stb.alloc) begin
          seqMem[wrIdx] <= seqCtr;
          seqCtr        <= seqCtr + SEQ_W'(1);
        end
        if (stb.grad) begin
          headIdx   <= headIdx + IDX_W'(1);
          committed <= committed + CNT_W'(1);
        end
        occ <= occ - freeCnt + OCC_W'(stb.alloc);
        if (stb.nsSet) begin
          nsFlag <= 1'b1;
          nsTag  <= nsSeqIn;
        end else if (nsFlag && (|nsHit)) begin
          nsFlag <= 1'b0;
        end
      end
    end

    assign occupancy[t] = occ;
    assign headSeq[t]   = (occ != '0) ? seqMem[headIdx] : '0;
    assign tailSeq[t]   = (occ != '0) ? seqMem[tailIdx] : '0;
    assign nextSeq[t]   = seqCtr;
    assign commitCnt[t] = committed;
    assign nsActive[t]  = nsFlag;
  end

endmodule

// File: rtl/inflight_tracker.sv
`timescale 1ns/1ps
module inflight_tracker
  import inflight_tracker_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,   // power of two
  parameter int SEQ_W       = 16,
  parameter int CNT_W       = 16,
  parameter int NUM_STAGES  = 5,
  localparam int TID_W      = atLeastOne($clog2(NUM_THREADS)),
  localparam int IDX_W      = atLeastOne($clog2(DEPTH)),
  localparam int OCC_W      = $clog2(DEPTH + 1),
  localparam int STG_W      = atLeastOne($clog2(NUM_STAGES))
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                allocReq,
  input  logic [TID_W-1:0]                    allocTid,
  output logic                                allocAck,
  output logic [SEQ_W-1:0]                    allocSeq,
  input  logic                                gradReq,
  input  logic [TID_W-1:0]                    gradTid,
  input  logic                                squashReq,
  input  logic [TID_W-1:0]                    squashTid,
  input  logic [SEQ_W-1:0]                    squashSeq,
  input  logic                                squashMemStall,
  input  logic [STG_W-1:0]                    squashStage,
  input  logic                                nsSetReq,
  input  logic [TID_W-1:0]                    nsTid,
  input  logic [SEQ_W-1:0]                    nsSeq,
  output logic [NUM_THREADS-1:0][OCC_W-1:0]   occupancy,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   headSeq,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   tailSeq,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]   commitCnt,
  output logic [NUM_THREADS-1:0]              nsActive,
  output logic [NUM_STAGES-1:0]               stageKill,
  output logic [TID_W-1:0]                    stageKillTid,
  output logic [SEQ_W-1:0]                    stageKillSeq
);

  trkStrobe_t [NUM_THREADS-1:0]      strobes;
  logic [SEQ_W-1:0]                  effSeq;
  logic [NUM_THREADS-1:0][SEQ_W-1:0] nextSeq;

  trk_ctrl #(
    .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W),
    .NUM_STAGES(NUM_STAGES), .TID_W(TID_W), .OCC_W(OCC_W), .STG_W(STG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocTid(allocTid),
    .gradReq(gradReq), .gradTid(gradTid),
    .squashReq(squashReq), .squashTid(squashTid), .squashSeq(squashSeq),
    .squashMemStall(squashMemStall), .squashStage(squashStage),
    .nsSetReq(nsSetReq), .nsTid(nsTid),
    .occupancy(occupancy),
    .strobes(strobes), .effSeq(effSeq), .allocAck(allocAck),
    .stageKill(stageKill), .stageKillTid(stageKillTid), .stageKillSeq(stageKillSeq)
  );

  trk_datapath #(
    .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .effSeq(effSeq), .nsSeqIn(nsSeq),
    .occupancy(occupancy), .headSeq(headSeq), .tailSeq(tailSeq),
    .nextSeq(nextSeq), .commitCnt(commitCnt), .nsActive(nsActive)
  );

  assign allocSeq = nextSeq[allocTid];

endmodule

// File: rtl/inflight_tracker_chk.sv
`timescale 1ns/1ps
module inflight_tracker_chk #(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,
  parameter int CNT_W       = 16,
  parameter int NUM_STAGES  = 5,
  parameter int TID_W       = 1,
  parameter int OCC_W       = 3
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              allocReq,
  input logic [TID_W-1:0]                  allocTid,
  input logic                              allocAck,
  input logic                              gradReq,
  input logic [TID_W-1:0]                  gradTid,
  input logic                              squashReq,
  input logic [TID_W-1:0]                  squashTid,
  input logic                              nsSetReq,
  input logic [TID_W-1:0]                  nsTid,
  input logic [NUM_THREADS-1:0][OCC_W-1:0] occupancy,
  input logic [NUM_THREADS-1:0][CNT_W-1:0] commitCnt,
  input logic [NUM_THREADS-1:0]            nsActive,
  input logic [NUM_STAGES-1:0]             stageKill
);

  // R3: an accepted append always has room
  a_r3_ack_has_room: assert property (@(posedge clk) disable iff (!rstN)
    allocAck |-> (int'(occupancy[allocTid]) < DEPTH));

  // R9: squash on the same thread blocks the append
  a_r9_squash_beats_alloc: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && squashReq && (allocTid == squashTid)) |-> !allocAck);

  // R6: kill mask follows a squash by one edge, idle otherwise
  a_r6_kill_after_squash: assert property (@(posedge clk) disable iff (!rstN)
    squashReq |=> stageKill[0]);
  a_r6_kill_idle: assert property (@(posedge clk) disable iff (!rstN)
    !squashReq |=> (stageKill == '0));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr_chk
    // R2: a list grows by at most one entry per cycle
    a_r2_growth_one: assert property (@(posedge clk) disable iff (!rstN)
      (int'(occupancy[t]) <= int'($past(occupancy[t])) + 1));

    // R7: graduation on a non-empty list advances the count by one
    a_r7_commit_step: assert property (@(posedge clk) disable iff (!rstN)
      (gradReq && (gradTid == TID_W'(t)) && (occupancy[t] != '0))
        |=> (commitCnt[t] == $past(commitCnt[t]) + CNT_W'(1)));

    // R10: the flag rises only after a set on its thread
    a_r10_rise_needs_set: assert property (@(posedge clk) disable iff (!rstN)
      $rose(nsActive[t]) |-> $past(nsSetReq && (nsTid == TID_W'(t))));
  end

endmodule

bind inflight_tracker inflight_tracker_chk #(
  .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .CNT_W(CNT_W),
  .NUM_STAGES(NUM_STAGES), .TID_W(TID_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .allocReq(allocReq), .allocTid(allocTid), .allocAck(allocAck),
  .gradReq(gradReq), .gradTid(gradTid),
  .squashReq(squashReq), .squashTid(squashTid),
  .nsSetReq(nsSetReq), .nsTid(nsTid),
  .occupancy(occupancy), .commitCnt(commitCnt),
  .nsActive(nsActive), .stageKill(stageKill)
);

// File: tb/inflight_tracker_test.sv
`timescale 1ns/1ps
module inflight_tracker_test;

  localparam int NT  = 2;
  localparam int DEP = 4;
  localparam int SW  = 16;
  localparam int CW  = 16;
  localparam int NS  = 5;
  localparam int TW  = 1;
  localparam int OW  = 3;
  localparam int GW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              allocReq = 0;
  logic [TW-1:0]     allocTid = 0;
  logic              allocAck;
  logic [SW-1:0]     allocSeq;
  logic              gradReq = 0;
  logic [TW-1:0]     gradTid = 0;
  logic              squashReq = 0;
  logic [TW-1:0]     squashTid = 0;
  logic [SW-1:0]     squashSeq = 0;
  logic              squashMemStall = 0;
  logic [GW-1:0]     squashStage = 0;
  logic              nsSetReq = 0;
  logic [TW-1:0]     nsTid = 0;
  logic [SW-1:0]     nsSeq = 0;
  logic [NT-1:0][OW-1:0] occupancy;
  logic [NT-1:0][SW-1:0] headSeq;
  logic [NT-1:0][SW-1:0] tailSeq;
  logic [NT-1:0][CW-1:0] commitCnt;
  logic [NT-1:0]         nsActive;
  logic [NS-1:0]         stageKill;
  logic [TW-1:0]         stageKillTid;
  logic [SW-1:0]         stageKillSeq;

  inflight_tracker #(.NUM_THREADS(NT), .DEPTH(DEP), .SEQ_W(SW), .CNT_W(CW),
                     .NUM_STAGES(NS)) uut (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocTid(allocTid), .allocAck(allocAck), .allocSeq(allocSeq),
    .gradReq(gradReq), .gradTid(gradTid),
    .squashReq(squashReq), .squashTid(squashTid), .squashSeq(squashSeq),
    .squashMemStall(squashMemStall), .squashStage(squashStage),
    .nsSetReq(nsSetReq), .nsTid(nsTid), .nsSeq(nsSeq),
    .occupancy(occupancy), .headSeq(headSeq), .tailSeq(tailSeq),
    .commitCnt(commitCnt), .nsActive(nsActive),
    .stageKill(stageKill), .stageKillTid(stageKillTid), .stageKillSeq(stageKillSeq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model
  int unsigned mq [NT][$];
  int unsigned mNext [NT];
  int unsigned mCommit [NT];
  bit          mNsF [NT];
  int unsigned mNsS [NT];
  int unsigned mKill, mKillTid, mKillSeq;
  int unsigned lfsr = 32'h1234_5678;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  task automatic checkState(input string tag);
    for (int t = 0; t < NT; t++) begin
      chk(tag, $sformatf("occupancy[%0d]", t), occupancy[t], mq[t].size());
      chk(tag, $sformatf("headSeq[%0d]", t), headSeq[t], (mq[t].size() != 0) ? mq[t][0] : 0);
      chk(tag, $sformatf("tailSeq[%0d]", t), tailSeq[t],
          (mq[t].size() != 0) ? mq[t][mq[t].size()-1] : 0);
      chk(tag, $sformatf("commitCnt[%0d]", t), commitCnt[t], mCommit[t]);
      chk(tag, $sformatf("nsActive[%0d]", t), nsActive[t], mNsF[t]);
    end
    chk(tag, "stageKill", stageKill, mKill);
    chk(tag, "stageKillTid", stageKillTid, mKillTid);
    chk(tag, "stageKillSeq", stageKillSeq, mKillSeq);
  endtask

  task automatic step(input string tag,
                      input bit aR, input int aT,
                      input bit gR, input int gT,
                      input bit sR, input int sT, input int unsigned sS, input bit sM, input int sStg,
                      input bit nR, input int nT, input int unsigned nS);
    bit expAck;
    int unsigned eff;
    @(negedge clk);
    allocReq = aR; allocTid = TW'(aT);
    gradReq = gR; gradTid = TW'(gT);
    squashReq = sR; squashTid = TW'(sT); squashSeq = SW'(sS);
    squashMemStall = sM; squashStage = GW'(sStg);
    nsSetReq = nR; nsTid = TW'(nT); nsSeq = SW'(nS);
    expAck = aR && (mq[aT].size() < DEP) && !(sR && sT == aT);
    eff = (sS - (sM ? 1 : 0)) & 32'hFFFF;
    #1;
    chk(tag, "allocAck (R3/R9)", allocAck, expAck);
    if (expAck) chk(tag, "allocSeq (R2)", allocSeq, mNext[aT]);
    // model update, mirroring the edge
    for (int t = 0; t < NT; t++) begin
      int unsigned kept[$];
      bit nsClr = 0;
      for (int i = 0; i < mq[t].size(); i++) begin
        bit m = (gR && gT == t && i == 0) || (sR && sT == t && mq[t][i] > eff);
        if (m && mq[t][i] == mNsS[t]) nsClr = 1;
        if (!m) kept.push_back(mq[t][i]);
      end
      if (gR && gT == t && mq[t].size() != 0) mCommit[t]++;
      if (expAck && aT == t) begin
        kept.push_back(mNext[t]);
        mNext[t]++;
      end
      mq[t] = kept;
      if (nR && nT == t) begin
        mNsF[t] = 1; mNsS[t] = nS;
      end else if (nsClr && mNsF[t]) mNsF[t] = 0;
    end
    mKill = 0;
    if (sR) for (int s = 0; s < NS; s++) if (s <= sStg) mKill |= (1 << s);
    mKillTid = sR ? sT : 0;
    mKillSeq = sR ? eff : 0;
    @(posedge clk);
    #1;
    checkState(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0,0, 0,0, 0,0,0,0,0, 0,0,0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      mNext[t] = 1; mCommit[t] = 0; mNsF[t] = 0; mNsS[t] = 0;
    end
    mKill = 0; mKillTid = 0; mKillSeq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkState("R1 reset");

    // R1/R2: fill thread 0; first seq is 1
    for (int k = 0; k < DEP; k++) step("R1 R2 fill", 1,0, 0,0, 0,0,0,0,0, 0,0,0);
    chk("R2", "tailSeq[0] after fill", tailSeq[0], 4);
    // R3: full stall, also with a graduation in the same cycle
    step("R3 full", 1,0, 0,0, 0,0,0,0,0, 0,0,0);
    step("R3 full+grad", 1,0, 1,0, 0,0,0,0,0, 0,0,0);
    step("R3 room again", 1,0, 0,0, 0,0,0,0,0, 0,0,0);     // q0=[2,3,4,5]
    // R4: plain squash keeps entries <= 3
    step("R4 squash", 0,0, 0,0, 1,0,3,0,2, 0,0,0);           // q0=[2,3]
    chk("R4", "tailSeq[0] after squash", tailSeq[0], 3);
    idle("R6 kill clears");
    // R9: same-thread squash blocks append; R11 other thread unaffected
    step("R9 same thread", 1,0, 0,0, 1,0,9,0,0, 0,0,0);
    step("R9 R11 other thread", 1,1, 0,0, 1,0,9,0,1, 0,0,0);
    // R5 R6: memory-stall squash on seq 3 from stage 4 drops seq 3
    step("R5 R6 memstall", 0,0, 0,0, 1,0,3,1,4, 0,0,0);      // q0=[2]
    chk("R5", "occupancy[0] after memstall", occupancy[0], 1);
    step("R6 stage beyond last", 0,0, 0,0, 1,1,50,0,7, 0,0,0);
    // R8: grad and squash both mark the head
    step("R8 prep", 1,0, 0,0, 0,0,0,0,0, 0,0,0);
    step("R8 prep", 1,0, 0,0, 0,0,0,0,0, 0,0,0);             // q0=[2,6,7]
    step("R8 double mark", 0,0, 1,0, 1,0,1,0,0, 0,0,0);
    chk("R8", "occupancy[0] after double mark", occupancy[0], 0);
    // R7: graduation of an empty list
    step("R7 empty grad", 0,0, 1,0, 0,0,0,0,0, 0,0,0);
    chk("R7", "commitCnt[0] unchanged", commitCnt[0], 2);
    // R10: flag set, unrelated free keeps it, matching free clears it
    step("R10 prep", 1,1, 0,0, 0,0,0,0,0, 0,0,0);
    step("R10 prep", 1,1, 0,0, 0,0,0,0,0, 0,0,0);
    step("R10 set", 0,0, 0,0, 0,0,0,0,0, 1,1,mq[1][1]);
    step("R10 other free", 0,0, 1,1, 0,0,0,0,0, 0,0,0);
    chk("R10", "nsActive[1] kept", nsActive[1], 1);
    step("R10 matching free", 0,0, 1,1, 0,0,0,0,0, 0,0,0);
    chk("R10", "nsActive[1] cleared", nsActive[1], 0);
    step("R10 set again", 0,0, 0,0, 0,0,0,0,0, 1,1,mq[1][0]);
    step("R10 squash clears", 0,0, 0,0, 1,1,mq[1][0],1,0, 0,0,0);
    chk("R10", "nsActive[1] cleared by squash", nsActive[1], 0);

    // R11: pseudo-random sweep over all operations on both threads
    for (int k = 0; k < 4000; k++) begin
      int unsigned r = rnd();
      int aT = r[0], gT = r[1], sT = r[2], nT = r[3];
      int unsigned sS = (mNext[sT] > (r[10:8] + 1)) ? mNext[sT] - r[10:8] - 1 : 1;
      int unsigned nS = (mq[nT].size() != 0) ? mq[nT][r[13:12] % mq[nT].size()] : r[23:20];
      step("R11 sweep", r[4] | r[5], aT, r[6] & r[7], gT, (r[14:12] == 0), sT, sS, r[15],
           int'(r[18:16]), (r[27:25] == 0), nT, nS);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule